// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides whether the protected output rail is powered from the main supply or from a backup cell, and it reports the result. It works only on digitized comparator results. These include whether the main supply is above the reset threshold, above the cell voltage, above an early-warning threshold slightly higher than the reset level, and above an absolute undervoltage floor, plus whether the cell is above its health threshold. A manual request can move the rail onto the cell while the main supply is still good.

A second function watches the health of the cell. Once the surrounding system reports that reset has been released, the block opens a short measurement window at a fixed period. It samples the cell comparator on the last clock of each window. A failed measurement pulls the health flag low, and the flag stays low until power-on clear. Every comparator input and control input first passes through a multi-flop synchronizer.

Top module: `supply_switchover`

## Requirements
- R1: With the floor comparator high, `use_backup` goes high when `vdd_gt_rst` and `vdd_gt_cell` are both low.
- R2: With the floor comparator high and no manual hold, the rail stays on the main supply (`use_backup` low) when either `vdd_gt_rst` or `vdd_gt_cell` is high.
- R3: When `vdd_gt_floor` is low, `use_backup` goes high whatever the value of `vdd_gt_cell`.
- R4: A high `force_backup` while on the main supply moves the rail to the cell. In that state `force_backup` is ignored. The manual hold ends only when `vdd_gt_rst` falls, after which R1 to R3 decide the rail.
- R5: From automatic backup, the rail returns to the main supply on the first cycle that `vdd_gt_floor` is high together with `vdd_gt_cell` or `vdd_gt_rst`.
- R6: `backup_active` is high exactly when the rail is fed from the cell.
- R7: `vdd_margin_ok` follows `vdd_gt_warn`: high above the early-warning threshold, low below it.
- R8: No measurement window opens while `rst_done` is low. Once it is high, `cell_probe_en` is high for `WINDOW_CYCLES` consecutive cycles, and a window starts every `PERIOD_CYCLES` cycles.
- R9: `cell_ok` is high after reset. It falls only if `cell_gt_ok` is low on the last cycle of a window. It ignores the comparator outside windows and never rises again before reset.
- R10: While `rst_n` is low, `use_backup` and `backup_active` are low, `cell_probe_en` is low, and `cell_ok` and `vdd_margin_ok` are high.
- R11: Each input passes through `SYNC_STAGES` flops. `vdd_margin_ok` reflects a change after `SYNC_STAGES` clock edges, and `use_backup` reflects it one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| vdd_gt_rst | input | 1 | Main supply above reset threshold |
| vdd_gt_cell | input | 1 | Main supply above cell voltage |
| vdd_gt_warn | input | 1 | Main supply above early-warning threshold |
| vdd_gt_floor | input | 1 | Main supply above undervoltage floor |
| cell_gt_ok | input | 1 | Cell above health threshold |
| force_backup | input | 1 | Manual request to run from the cell |
| rst_done | input | 1 | System reset has been released |
| use_backup | output | 1 | Rail select: 1 = cell, 0 = main supply |
| backup_active | output | 1 | Status: rail is on the cell |
| vdd_margin_ok | output | 1 | High while the supply is above the warning level |
| cell_ok | output | 1 | Cell health flag (sticky low) |
| cell_probe_en | output | 1 | Measurement window strobe |

## Verification
The selection logic is tried with all four combinations of the reset and cell comparisons with the floor high. This separates an AND from an OR in the battery condition. A floor drop with the supply above the cell shows that the floor overrides the comparison. Recoveries through the cell comparison alone and through the threshold alone show that either one is enough to return. A manual request is driven high, then low, then high again, and the supply then drops while it stays above the cell, so a latched hold can be told apart from a simple OR with the input. A low cell comparator is applied both outside a window and inside one, and before release, to show that only the last window cycle samples it.

// File: rtl/supply_switchover_pkg.sv
// Package: shared types and constants for the supply switchover controller.
// Assumes all comparator inputs are gathered into one vector in the index order below.
package supply_switchover_pkg;

    // Positions of each input inside the synchronized vector.
    localparam int IDX_VDD_RST   = 0;
    localparam int IDX_VDD_CELL  = 1;
    localparam int IDX_VDD_WARN  = 2;
    localparam int IDX_VDD_FLOOR = 3;
    localparam int IDX_CELL_OK   = 4;
    localparam int IDX_FORCE     = 5;
    localparam int IDX_RST_DONE  = 6;
    localparam int N_SYNC_IN     = 7;

    // Reset pattern: a healthy supply, no request, reset not yet released.
    localparam logic [N_SYNC_IN-1:0] SYNC_RST_PATTERN = 7'b001_1111;

    // Rail selection state.
    typedef enum logic [1:0] {
        SEL_MAIN   = 2'd0,
        SEL_AUTO   = 2'd1,
        SEL_MANUAL = 2'd2
    } sel_state_t;

endpackage

// File: rtl/ssw_sync.sv
// Module: ssw_sync
// Multi-flop synchronizer for a vector of asynchronous level inputs.
// Assumes inputs are slow levels; each bit is synchronized independently.
module ssw_sync #(
    parameter int              WIDTH   = 7,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // Later flops settle any metastability of the previous one.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ssw_select_fsm.sv
// Module: ssw_select_fsm
// Chooses the rail source from synchronized comparator levels.
// Automatic backup when the supply is under the floor, or under both the reset
// threshold and the cell voltage. A manual request latches backup until the
// supply drops below the reset threshold.
module ssw_select_fsm
    import supply_switchover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_rst_s,
    input  logic vdd_cell_s,
    input  logic vdd_floor_s,
    input  logic force_s,
    output logic on_cell
);

    sel_state_t state_q, state_d;
    logic       need_cell;

    // Automatic backup condition from the supply comparisons.
    always_comb begin
        need_cell = !vdd_floor_s || (!vdd_rst_s && !vdd_cell_s);
    end

    // Next-state decision for the rail selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_MAIN: begin
                if (need_cell)    state_d = SEL_AUTO;
                else if (force_s) state_d = SEL_MANUAL;
            end
            SEL_AUTO: begin
                if (!need_cell) state_d = SEL_MAIN;
            end
            SEL_MANUAL: begin
                if (!vdd_rst_s) state_d = need_cell ? SEL_AUTO : SEL_MAIN;
            end
            default: state_d = SEL_MAIN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_MAIN;
        else        state_q <= state_d;
    end

    assign on_cell = (state_q != SEL_MAIN);

endmodule

// File: rtl/ssw_cell_monitor.sv
// Module: ssw_cell_monitor
// Periodic cell-health probe. Opens a window of WINDOW_CYCLES every
// PERIOD_CYCLES once reset is released and samples the cell comparator on the
// last window cycle. A failed sample clears the sticky health flag.
module ssw_cell_monitor #(
    parameter int PERIOD_CYCLES = 50_000_000,
    parameter int WINDOW_CYCLES = 6_250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic released_s,
    input  logic cell_ok_s,
    output logic probe_en,
    output logic healthy
);

    localparam int CNT_W = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(WINDOW_CYCLES - 1);
    localparam logic [CNT_W-1:0] WIN_LEN  = CNT_W'(WINDOW_CYCLES);

    logic [CNT_W-1:0] phase_q;
    logic             last_win_cycle;

    // Phase counter: idle at zero before release, wraps each period after.
    always_ff @(posedge clk) begin
        if (!rst_n || !released_s) phase_q <= '0;
        else if (phase_q == CNT_LAST) phase_q <= '0;
        else                          phase_q <= phase_q + 1'b1;
    end

    assign probe_en       = released_s && (phase_q < WIN_LEN);
    assign last_win_cycle = released_s && (phase_q == WIN_END);

    // Sticky health flag updated only on the final window cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          healthy <= 1'b1;
        else if (last_win_cycle && !cell_ok_s) healthy <= 1'b0;
    end

endmodule

// File: rtl/supply_switchover.sv
// Module: supply_switchover (top)
// Backup supply switchover controller: synchronizes the comparator bits,
// selects the rail source, reports the early-warning level and runs the
// periodic cell-health probe. Assumes comparators are glitch-free levels.
module supply_switchover
    import supply_switchover_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int PERIOD_CYCLES = 50_000_000,
    parameter int WINDOW_CYCLES = 6_250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_gt_rst,
    input  logic vdd_gt_cell,
    input  logic vdd_gt_warn,
    input  logic vdd_gt_floor,
    input  logic cell_gt_ok,
    input  logic force_backup,
    input  logic rst_done,
    output logic use_backup,
    output logic backup_active,
    output logic vdd_margin_ok,
    output logic cell_ok,
    output logic cell_probe_en
);

    logic [N_SYNC_IN-1:0] raw_in, sync_in;
    logic vdd_rst_s, vdd_cell_s, vdd_warn_s, vdd_floor_s;
    logic cell_ok_s, force_s, released_s;
    logic on_cell;

    // Gather raw inputs in package index order.
    always_comb begin
        raw_in                = '0;
        raw_in[IDX_VDD_RST]   = vdd_gt_rst;
        raw_in[IDX_VDD_CELL]  = vdd_gt_cell;
        raw_in[IDX_VDD_WARN]  = vdd_gt_warn;
        raw_in[IDX_VDD_FLOOR] = vdd_gt_floor;
        raw_in[IDX_CELL_OK]   = cell_gt_ok;
        raw_in[IDX_FORCE]     = force_backup;
        raw_in[IDX_RST_DONE]  = rst_done;
    end

    ssw_sync #(
        .WIDTH   (N_SYNC_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST_PATTERN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (sync_in)
    );

    assign vdd_rst_s   = sync_in[IDX_VDD_RST];
    assign vdd_cell_s  = sync_in[IDX_VDD_CELL];
    assign vdd_warn_s  = sync_in[IDX_VDD_WARN];
    assign vdd_floor_s = sync_in[IDX_VDD_FLOOR];
    assign cell_ok_s   = sync_in[IDX_CELL_OK];
    assign force_s     = sync_in[IDX_FORCE];
    assign released_s  = sync_in[IDX_RST_DONE];

    ssw_select_fsm u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .vdd_rst_s   (vdd_rst_s),
        .vdd_cell_s  (vdd_cell_s),
        .vdd_floor_s (vdd_floor_s),
        .force_s     (force_s),
        .on_cell     (on_cell)
    );

    ssw_cell_monitor #(
        .PERIOD_CYCLES (PERIOD_CYCLES),
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .released_s (released_s),
        .cell_ok_s  (cell_ok_s),
        .probe_en   (cell_probe_en),
        .healthy    (cell_ok)
    );

    assign use_backup    = on_cell;
    assign backup_active = on_cell;
    assign vdd_margin_ok = vdd_warn_s;

endmodule

// File: rtl/supply_switchover_chk.sv
// Module: supply_switchover_chk
// Property checker bound to supply_switchover; relates synchronized inputs to
// the rail select and the probe outputs over time.
module supply_switchover_chk #(
    parameter int WINDOW_CYCLES = 6_250
) (
    input logic clk,
    input logic rst_n,
    input logic use_backup,
    input logic backup_active,
    input logic cell_ok,
    input logic cell_probe_en,
    input logic vdd_rst_s,
    input logic vdd_cell_s,
    input logic vdd_floor_s,
    input logic force_s,
    input logic released_s
);

    int unsigned win_run;

    // Length of the current run of probe-window cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)             win_run <= 0;
        else if (cell_probe_en) win_run <= win_run + 1;
        else                    win_run <= 0;
    end

    a_r6_status_matches_select: assert property (@(posedge clk) disable iff (!rst_n)
        backup_active == use_backup);

    a_r1_entry_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_backup) |-> $past((!vdd_rst_s && !vdd_cell_s) || !vdd_floor_s || force_s));

    a_r5_exit_has_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(use_backup) |-> $past(vdd_floor_s && (vdd_cell_s || vdd_rst_s)));

    a_r3_floor_forces_cell: assert property (@(posedge clk) disable iff (!rst_n)
        !vdd_floor_s |=> use_backup);

    a_r8_no_probe_unreleased: assert property (@(posedge clk) disable iff (!rst_n)
        !released_s |-> !cell_probe_en);

    a_r8_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        cell_probe_en |-> (win_run < WINDOW_CYCLES));

    a_r9_health_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_ok |=> !cell_ok);

endmodule

bind supply_switchover supply_switchover_chk #(
    .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .use_backup    (use_backup),
    .backup_active (backup_active),
    .cell_ok       (cell_ok),
    .cell_probe_en (cell_probe_en),
    .vdd_rst_s     (vdd_rst_s),
    .vdd_cell_s    (vdd_cell_s),
    .vdd_floor_s   (vdd_floor_s),
    .force_s       (force_s),
    .released_s    (released_s)
);

// File: tb/tb_supply_switchover.sv
// Directed bench for supply_switchover; one task per scenario.
module tb_supply_switchover;

    localparam int SYNC   = 2;
    localparam int PERIOD = 40;
    localparam int WINDOW = 5;
    localparam int SETTLE = SYNC + 3;

    logic clk = 1'b0;
    logic rst_n;
    logic vdd_gt_rst, vdd_gt_cell, vdd_gt_warn, vdd_gt_floor;
    logic cell_gt_ok, force_backup, rst_done;
    logic use_backup, backup_active, vdd_margin_ok, cell_ok, cell_probe_en;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    supply_switchover #(
        .SYNC_STAGES   (SYNC),
        .PERIOD_CYCLES (PERIOD),
        .WINDOW_CYCLES (WINDOW)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .vdd_gt_rst    (vdd_gt_rst),
        .vdd_gt_cell   (vdd_gt_cell),
        .vdd_gt_warn   (vdd_gt_warn),
        .vdd_gt_floor  (vdd_gt_floor),
        .cell_gt_ok    (cell_gt_ok),
        .force_backup  (force_backup),
        .rst_done      (rst_done),
        .use_backup    (use_backup),
        .backup_active (backup_active),
        .vdd_margin_ok (vdd_margin_ok),
        .cell_ok       (cell_ok),
        .cell_probe_en (cell_probe_en)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic supply(input logic rst_cmp, input logic cell_cmp, input logic floor_cmp);
        vdd_gt_rst   = rst_cmp;
        vdd_gt_cell  = cell_cmp;
        vdd_gt_floor = floor_cmp;
    endtask

    // Checks the rail select and its status copy together.
    task automatic check_rail(input string tag, input logic expect_cell);
        check({tag, " use_backup"}, int'(use_backup), int'(expect_cell));
        check({"R6 ", tag, " backup_active"}, int'(backup_active), int'(expect_cell));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        supply(1'b1, 1'b1, 1'b1);
        vdd_gt_warn = 1'b1; cell_gt_ok = 1'b1; force_backup = 1'b0; rst_done = 1'b0;
        cycles(4);
        check("R10 use_backup", int'(use_backup), 0);
        check("R10 backup_active", int'(backup_active), 0);
        check("R10 cell_probe_en", int'(cell_probe_en), 0);
        check("R10 cell_ok", int'(cell_ok), 1);
        check("R10 vdd_margin_ok", int'(vdd_margin_ok), 1);
        rst_n = 1'b1;
        cycles(SETTLE);
    endtask

    task automatic t_prerelease();
        int seen = 0;
        cell_gt_ok = 1'b0;
        for (int i = 0; i < 3 * PERIOD; i++) begin
            @(negedge clk);
            if (cell_probe_en) seen++;
        end
        check("R8 no window before release", seen, 0);
        check("R9 cell_ok untouched before release", int'(cell_ok), 1);
        cell_gt_ok = 1'b1;
        cycles(SETTLE);
    endtask

    task automatic t_auto_select();
        supply(1'b0, 1'b0, 1'b1); cycles(SETTLE);
        check_rail("R1 below rst and cell", 1'b1);
        supply(1'b0, 1'b1, 1'b1); cycles(SETTLE);
        check_rail("R5 recover via cell compare", 1'b0);
        supply(1'b0, 1'b1, 1'b1); cycles(SETTLE);
        check_rail("R2 below rst above cell", 1'b0);
        supply(1'b1, 1'b0, 1'b1); cycles(SETTLE);
        check_rail("R2 above rst below cell", 1'b0);
        supply(1'b0, 1'b0, 1'b1); cycles(SETTLE);
        check_rail("R1 second entry", 1'b1);
        supply(1'b1, 1'b0, 1'b1); cycles(SETTLE);
        check_rail("R5 recover via threshold", 1'b0);
    endtask

    task automatic t_floor();
        supply(1'b0, 1'b1, 1'b0); cycles(SETTLE);
        check_rail("R3 under floor above cell", 1'b1);
        supply(1'b0, 1'b1, 1'b1); cycles(SETTLE);
        check_rail("R5 floor restored", 1'b0);
        supply(1'b1, 1'b1, 1'b1); cycles(SETTLE);
    endtask

    task automatic t_manual();
        force_backup = 1'b1; cycles(SETTLE);
        check_rail("R4 manual request", 1'b1);
        force_backup = 1'b0; cycles(SETTLE);
        check_rail("R4 request released, hold kept", 1'b1);
        force_backup = 1'b1; cycles(SETTLE);
        force_backup = 1'b0; cycles(SETTLE);
        check_rail("R4 request toggled in backup", 1'b1);
        supply(1'b0, 1'b1, 1'b1); cycles(SETTLE);
        check_rail("R4 hold ends on supply drop", 1'b0);
        supply(1'b1, 1'b1, 1'b1); cycles(SETTLE);
        check_rail("R2 healthy after manual", 1'b0);
    endtask

    task automatic t_latency();
        supply(1'b0, 1'b0, 1'b1);
        vdd_gt_warn = 1'b0;
        cycles(1);
        check("R11 margin one edge", int'(vdd_margin_ok), 1);
        cycles(SYNC - 1);
        check("R7 margin low after sync", int'(vdd_margin_ok), 0);
        check("R11 select not yet", int'(use_backup), 0);
        cycles(1);
        check("R11 select after sync plus one", int'(use_backup), 1);
        vdd_gt_warn = 1'b1;
        supply(1'b1, 1'b1, 1'b1);
        cycles(SETTLE);
        check("R7 margin high", int'(vdd_margin_ok), 1);
        check_rail("R5 back to main", 1'b0);
    endtask

    task automatic t_probe();
        int first_rise = -1, second_rise = -1, width = 0;
        logic prev = 1'b0;
        rst_done = 1'b1;
        for (int i = 1; i <= 2 * PERIOD + SYNC + 2; i++) begin
            @(negedge clk);
            if (cell_probe_en && !prev) begin
                if (first_rise < 0) first_rise = i;
                else if (second_rise < 0) second_rise = i;
            end
            if (cell_probe_en && second_rise < 0) width++;
            prev = cell_probe_en;
        end
        check("R8 first window start", first_rise, SYNC);
        check("R8 window width", width, WINDOW);
        check("R8 window period", second_rise - first_rise, PERIOD);
    endtask

    task automatic wait_window_end();
        int guard = 0;
        while (!cell_probe_en && guard < 4 * PERIOD) begin @(negedge clk); guard++; end
        while (cell_probe_en && guard < 4 * PERIOD) begin @(negedge clk); guard++; end
    endtask

    task automatic t_health();
        wait_window_end();
        cell_gt_ok = 1'b0; cycles(10); cell_gt_ok = 1'b1;
        wait_window_end();
        check("R9 low outside window ignored", int'(cell_ok), 1);
        cell_gt_ok = 1'b0;
        wait_window_end();
        check("R9 low in window clears", int'(cell_ok), 0);
        cell_gt_ok = 1'b1;
        wait_window_end();
        wait_window_end();
        check("R9 stays low after recovery", int'(cell_ok), 0);
    endtask

    initial begin
        #(200_000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_prerelease();
        t_auto_select();
        t_floor();
        t_manual();
        t_latency();
        t_probe();
        t_health();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule